// File: doc/BRIEF.md
# Video DAC Control-Level Compositor

This block is the synchronous front end of a three-channel video output stage. On each rising clock edge it captures an 8-bit red, green and blue pixel code together with three video controls: sync, blank and force-white. For every channel it then forms a composite output level, expressed as an integer code in fixed units. The level is built from three terms: a pixel term, a black-level pedestal, and a sync term. The sync term is added to one chosen channel only, which supports sync-on-green operation.

The controls travel through the same registers as the pixel codes, so each control always acts on the pixel captured on the same edge. The controls follow a fixed priority. Blank beats force-white, and the sync term is independent of both. A power-down input acts at once and does not wait for a clock edge. While it is high it zeroes every output and freezes every stored value.

One unit equals one data LSB. The pedestal is 21 units and the sync term is 111 units, so the channel that carries sync ranges from 0 to 387 and every other channel ranges from 0 to 276.

Top module: `vdac_compositor`

## Requirements
- R1: While reset is held, and after reset is released with no further input, all three level outputs read 0.
- R2: A pixel code and its controls sampled on clock edge k appear together at the outputs after edge k+PIPE_DEPTH-1. The outputs are sampled after that edge and before the next one. PIPE_DEPTH may be 1 or 2.
- R3: When blank_n is 0, the pixel code and force_white are ignored. The pixel term and the pedestal term are both 0 on every channel.
- R4: When blank_n is 1 and force_white is 0, a channel's level equals its pixel code plus 21, plus the sync term if that channel carries sync.
- R5: When blank_n is 1 and force_white is 1, each channel's pixel term is 255, so its level is 276 plus its sync term. When blank_n is 0, force_white has no effect.
- R6: SYNC_SEL chooses the channel that carries the sync term: 0 selects red, 1 selects green, 2 selects blue, and 3 selects none. The default is green. On that channel, sync_n = 1 adds 111 units and sync_n = 0 removes them. A blanked channel with sync_n = 0 therefore reads 0, which is the sync tip.
- R7: If sync_n is 0 while blank_n is 1, the block does not block it and does not alter any other term. The sync term is simply missing from the level.
- R8: While pwr_down is 1, all outputs are 0 with no clock edge needed, and no pipeline or output register changes. When pwr_down returns to 0, the values held before power-down are shown again.
- R9: The channel that carries sync never exceeds 387, and every other channel never exceeds 276.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all capture happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; sets every register to 0 |
| pwr_down | input | 1 | Asynchronous power-down; zeroes the outputs and freezes all registers |
| pix_r | input | 8 | Red pixel code |
| pix_g | input | 8 | Green pixel code |
| pix_b | input | 8 | Blue pixel code |
| sync_n | input | 1 | 1 adds the sync term on the selected channel; 0 removes it (sync tip) |
| blank_n | input | 1 | 0 blanks all channels; 1 enables the pixel and pedestal terms |
| force_white | input | 1 | 1 forces every pixel term to full scale, unless blanking is active |
| lvl_r | output | 9 | Red composite level code |
| lvl_g | output | 9 | Green composite level code |
| lvl_b | output | 9 | Blue composite level code |

## Verification
The bench builds the block with PIPE_DEPTH = 2 and SYNC_SEL = 1 (green). This is the deepest pipeline the block allows, so the checks can tell a capture register apart from the output register. It also means a wrong latency or a control that is out of step with its pixel shows up as a change one cycle early or one cycle late. Because sync goes to green, the red and blue channels act as references without sync while green takes the 111-unit term. This makes a misrouted or leaking sync term directly visible. Because there are two register stages, the power-down test can confirm that both stages hold their values across a sleep period.

// File: rtl/vdac_pkg.sv
package vdac_pkg;

  // Which channel receives the sync term
  typedef enum logic [1:0] {
    SYNC_TO_RED   = 2'd0,
    SYNC_TO_GREEN = 2'd1,
    SYNC_TO_BLUE  = 2'd2,
    SYNC_TO_NONE  = 2'd3
  } sync_route_e;

  // Controls that travel in step with a pixel
  typedef struct packed {
    logic sync_n;
    logic blank_n;
    logic white;
  } vid_ctl_t;

  // Bits needed to hold the highest possible level
  function automatic int level_width(int data_w, int ped, int syn);
    int top_level;
    top_level = (1 << data_w) - 1 + ped + syn;
    return $clog2(top_level + 1);
  endfunction

  // Composite level: pixel term and pedestal gated by blank, plus sync term
  function automatic int level_of(int code, logic blank_n, logic white,
                                  logic sync_n, bit carries, int full,
                                  int ped, int syn);
    int pix;
    int lvl;
    pix = white ? full : code;
    lvl = blank_n ? (pix + ped) : 0;
    if (carries && sync_n) lvl = lvl + syn;
    return lvl;
  endfunction

endpackage

// File: rtl/vdac_stage_line.sv
module vdac_stage_line #(
  parameter int W      = 27,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stage_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else if (!hold) begin
          stage_q[0] <= d;
          for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign q = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/vdac_level_calc.sv
module vdac_level_calc #(
  parameter int DATA_W       = 8,
  parameter int OUT_W        = 9,
  parameter int PED_UNITS    = 21,
  parameter int SYNC_UNITS   = 111,
  parameter bit CARRIES_SYNC = 1'b0
) (
  input  logic [DATA_W-1:0] code,
  input  vdac_pkg::vid_ctl_t ctl,
  output logic [OUT_W-1:0]  level
);
  localparam int FULL = (1 << DATA_W) - 1;

  always_comb begin
    level = OUT_W'(vdac_pkg::level_of(int'(code), ctl.blank_n, ctl.white,
                                      ctl.sync_n, CARRIES_SYNC, FULL,
                                      PED_UNITS, SYNC_UNITS));
  end
endmodule

// File: rtl/vdac_compositor.sv
module vdac_compositor #(
  parameter int         DATA_W     = 8,
  parameter int         PIPE_DEPTH = 2,
  parameter int         PED_UNITS  = 21,
  parameter int         SYNC_UNITS = 111,
  parameter logic [1:0] SYNC_SEL   = 2'd1,
  parameter int         OUT_W      = vdac_pkg::level_width(DATA_W, PED_UNITS, SYNC_UNITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic [DATA_W-1:0] pix_r,
  input  logic [DATA_W-1:0] pix_g,
  input  logic [DATA_W-1:0] pix_b,
  input  logic              sync_n,
  input  logic              blank_n,
  input  logic              force_white,
  output logic [OUT_W-1:0]  lvl_r,
  output logic [OUT_W-1:0]  lvl_g,
  output logic [OUT_W-1:0]  lvl_b
);
  localparam int NCH    = 3;
  localparam int CTL_W  = $bits(vdac_pkg::vid_ctl_t);
  localparam int BUS_W  = NCH * DATA_W + CTL_W;
  localparam int STAGES = PIPE_DEPTH - 1;

  vdac_pkg::vid_ctl_t ctl_in, ctl_d, ctl_q;
  logic [BUS_W-1:0]   bus_in, bus_d;
  logic [DATA_W-1:0]  code_d  [NCH];
  logic [OUT_W-1:0]   level_c [NCH];
  logic [OUT_W-1:0]   level_q [NCH];

  assign ctl_in = '{sync_n: sync_n, blank_n: blank_n, white: force_white};
  assign bus_in = {pix_r, pix_g, pix_b, ctl_in};

  // Delay stages shared by data and controls
  vdac_stage_line #(.W(BUS_W), .STAGES(STAGES)) u_line (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (pwr_down),
    .d    (bus_in),
    .q    (bus_d)
  );

  assign {code_d[0], code_d[1], code_d[2], ctl_d} = bus_d;

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      vdac_level_calc #(
        .DATA_W      (DATA_W),
        .OUT_W       (OUT_W),
        .PED_UNITS   (PED_UNITS),
        .SYNC_UNITS  (SYNC_UNITS),
        .CARRIES_SYNC(SYNC_SEL == ch)
      ) u_calc (
        .code (code_d[ch]),
        .ctl  (ctl_d),
        .level(level_c[ch])
      );
    end
  endgenerate

  // Output register; the control copy is kept for the checker
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int ch = 0; ch < NCH; ch++) level_q[ch] <= '0;
      ctl_q <= '0;
    end else if (!pwr_down) begin
      for (int ch = 0; ch < NCH; ch++) level_q[ch] <= level_c[ch];
      ctl_q <= ctl_d;
    end
  end

  // Power-down zeroes the outputs without a clock
  assign lvl_r = pwr_down ? '0 : level_q[0];
  assign lvl_g = pwr_down ? '0 : level_q[1];
  assign lvl_b = pwr_down ? '0 : level_q[2];
endmodule

// File: rtl/vdac_compositor_chk.sv
module vdac_compositor_chk #(
  parameter int         DATA_W     = 8,
  parameter int         PED_UNITS  = 21,
  parameter int         SYNC_UNITS = 111,
  parameter logic [1:0] SYNC_SEL   = 2'd1,
  parameter int         OUT_W      = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_down,
  input logic             ctl_sync_n,
  input logic             ctl_blank_n,
  input logic             ctl_white,
  input logic [OUT_W-1:0] raw_r,
  input logic [OUT_W-1:0] raw_g,
  input logic [OUT_W-1:0] raw_b,
  input logic [OUT_W-1:0] lvl_r,
  input logic [OUT_W-1:0] lvl_g,
  input logic [OUT_W-1:0] lvl_b
);
  localparam int FULL = (1 << DATA_W) - 1;
  localparam int PLAIN_CAP = FULL + PED_UNITS;

  logic [OUT_W-1:0] lvl_a [3];
  assign lvl_a[0] = lvl_r;
  assign lvl_a[1] = lvl_g;
  assign lvl_a[2] = lvl_b;

  // R8: outputs zero during power-down
  assert_sleep_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (lvl_r == '0 && lvl_g == '0 && lvl_b == '0));

  // R8: stored levels frozen during power-down
  assert_sleep_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> ($stable(raw_r) && $stable(raw_g) && $stable(raw_b)));

  generate
    for (genvar ch = 0; ch < 3; ch++) begin : g_ch
      localparam bit CARRY = (SYNC_SEL == ch);
      localparam int CAP   = CARRY ? PLAIN_CAP + SYNC_UNITS : PLAIN_CAP;

      // R3 / R6: blanked with sync removed is the zero level
      assert_blank_tip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down && !ctl_blank_n && !ctl_sync_n) |-> (lvl_a[ch] == '0));

      // R9: level ceiling
      assert_ceiling_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(lvl_a[ch]) <= CAP);

      // R5: white drives non-sync channels to full scale plus pedestal
      if (!CARRY) begin : g_plain
        assert_white_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
          (!pwr_down && ctl_blank_n && ctl_white) |-> (int'(lvl_a[ch]) == PLAIN_CAP));
      end
    end
  endgenerate
endmodule

bind vdac_compositor vdac_compositor_chk #(
  .DATA_W    (DATA_W),
  .PED_UNITS (PED_UNITS),
  .SYNC_UNITS(SYNC_UNITS),
  .SYNC_SEL  (SYNC_SEL),
  .OUT_W     (OUT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_down   (pwr_down),
  .ctl_sync_n (ctl_q.sync_n),
  .ctl_blank_n(ctl_q.blank_n),
  .ctl_white  (ctl_q.white),
  .raw_r      (level_q[0]),
  .raw_g      (level_q[1]),
  .raw_b      (level_q[2]),
  .lvl_r      (lvl_r),
  .lvl_g      (lvl_g),
  .lvl_b      (lvl_b)
);

// File: tb/tb_vdac_compositor.sv
`timescale 1ns/1ps
module tb_vdac_compositor;
  localparam int PIPE = 2;
  localparam int SEL  = 1;  // green carries sync

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_down = 1'b0;
  logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic       sync_n = 1'b0, blank_n = 1'b0, force_white = 1'b0;
  logic [8:0] lvl_r, lvl_g, lvl_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vdac_compositor #(.PIPE_DEPTH(PIPE), .SYNC_SEL(2'(SEL))) dut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .sync_n(sync_n), .blank_n(blank_n), .force_white(force_white),
    .lvl_r(lvl_r), .lvl_g(lvl_g), .lvl_b(lvl_b)
  );

  // Reference: sync term first, then the blank-gated picture part
  function automatic int expect_lvl(int code, bit s, bit bl, bit w, bit carry);
    int acc = 0;
    if (carry && s) acc = 111;
    if (bl) acc += 21 + (w ? 255 : code);
    return acc;
  endfunction

  task automatic cmp(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic drive(int r, int g, int b, bit s, bit bl, bit w);
    @(negedge clk);
    pix_r = 8'(r); pix_g = 8'(g); pix_b = 8'(b);
    sync_n = s; blank_n = bl; force_white = w;
  endtask

  task automatic settle();
    repeat (PIPE) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(string tag, int r, int g, int b, bit s, bit bl, bit w);
    cmp({tag, " red"},   int'(lvl_r), expect_lvl(r, s, bl, w, SEL == 0));
    cmp({tag, " green"}, int'(lvl_g), expect_lvl(g, s, bl, w, SEL == 1));
    cmp({tag, " blue"},  int'(lvl_b), expect_lvl(b, s, bl, w, SEL == 2));
  endtask

  // R1: reset state
  task automatic t_reset();
    #1;
    cmp("R1 in reset red", int'(lvl_r), 0);
    cmp("R1 in reset green", int'(lvl_g), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 after reset", 0, 0, 0, 1'b0, 1'b0, 1'b0);
  endtask

  // R3 R4 R5 R6 R7: codes 0,1,254,255 under every control combination
  task automatic t_sweep();
    int codes [4] = '{0, 1, 254, 255};
    for (int ci = 0; ci < 4; ci++)
      for (int k = 0; k < 8; k++) begin
        bit s  = k[2];
        bit bl = k[1];
        bit w  = k[0];
        int c  = codes[ci];
        string tag;
        if (!bl) tag = s ? "R3 blank R6 sync" : "R3 R6 tip";
        else if (w) tag = s ? "R5 white R6" : "R5 white R7";
        else tag = s ? "R4 active R6" : "R4 active R7";
        if (bl && !s) $display("WARN R7: sync tip requested during active video, code %0d", c);
        drive(c, 255 - c, c, s, bl, w);
        settle();
        check_all(tag, c, 255 - c, c, s, bl, w);
      end
  endtask

  // R2: data and controls arrive together after PIPE edges
  task automatic t_latency();
    drive(100, 50, 200, 1'b1, 1'b1, 1'b0);
    settle();
    drive(7, 9, 11, 1'b0, 1'b0, 1'b0);
    repeat (PIPE - 1) @(posedge clk);
    @(negedge clk);
    check_all("R2 before arrival", 100, 50, 200, 1'b1, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    check_all("R2 on arrival", 7, 9, 11, 1'b0, 1'b0, 1'b0);
    drive(30, 31, 32, 1'b1, 1'b1, 1'b1);
    repeat (PIPE) @(posedge clk);
    @(negedge clk);
    check_all("R2 white aligned", 30, 31, 32, 1'b1, 1'b1, 1'b1);
  endtask

  // R8: power-down zeroes outputs and keeps stored values
  task automatic t_sleep();
    drive(40, 60, 80, 1'b1, 1'b1, 1'b0);
    settle();
    @(negedge clk); pwr_down = 1'b1;
    #1;
    check_all("R8 asleep now", 0, 0, 0, 1'b0, 1'b0, 1'b0);
    pix_r = 8'd1; pix_g = 8'd2; pix_b = 8'd3; force_white = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R8 asleep held", 0, 0, 0, 1'b0, 1'b0, 1'b0);
    pwr_down = 1'b0;
    #1;
    check_all("R8 wake old value", 40, 60, 80, 1'b1, 1'b1, 1'b0);
    settle();
    check_all("R8 wake new value", 1, 2, 3, 1'b1, 1'b1, 1'b1);
  endtask

  // R9: ceilings
  task automatic t_ceiling();
    drive(255, 255, 255, 1'b1, 1'b1, 1'b0);
    settle();
    cmp("R9 sync channel max", int'(lvl_g), 387);
    cmp("R9 plain red max", int'(lvl_r), 276);
    cmp("R9 plain blue max", int'(lvl_b), 276);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_latency();
    t_sleep();
    t_ceiling();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule